// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one binary count-down timer channel. It runs only on cycles where a clock-enable tick is high. It drives a single output pin whose waveform is set by a 3-bit operating mode, a 16-bit reload value and a gate input. Six behaviours are available:

- a terminal-count flag that stays up once reached;
- a restartable one-shot;
- a rate generator that pulses once per period;
- a square wave;
- a single strobe that cannot be retriggered;
- a single strobe that the gate can retrigger.

The surrounding logic presents a reload value and a mode together with a one-cycle load strobe. The channel applies them at the next tick. A rising edge on the gate restarts the channel's timing in the modes that allow a retrigger. The visible count shows how far the channel is into its current period. The out pin is meant to feed an interrupt line or a clock divider.

Top module: `ivc_channel`

## Requirements
- R1: After reset the channel runs the square-wave mode with a period of 65536 ticks: out_o is 1 and count_o is 0.
- R2: A load is applied on the first cycle after the load cycle that has tick_i high. From that tick, elapsed time is zero and count_o equals the reload value. A reload of 0 means a period of 65536.
- R3: Mode code 0: out_o is 0 from the start tick until N ticks have elapsed (N is the period). It is then 1 until the next load is applied.
- R4: Mode code 1 behaves as mode 0. In addition, a rising gate edge restarts its elapsed time at the next tick, which drives out_o back to 0.
- R5: Mode code 2: out_o is 1 for one tick interval each time a full period completes. At that point count_o shows N again. Elapsed time then restarts.
- R6: Mode code 3: within each period, out_o is 1 for the first (N+1)/2 ticks and 0 for the rest. count_o equals N - (2·p mod N), where p is the number of ticks into the period.
- R7: Mode code 4: out_o is 1 for exactly one tick interval, when elapsed ticks equal N. It is 0 at all other times.
- R8: Mode code 5 behaves as mode 4. In addition, a rising gate edge restarts its elapsed time at the next tick.
- R9: In mode codes 0 and 4 a rising gate edge has no effect on out_o or count_o.
- R10: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R11: Cycles where tick_i is low change neither out_o nor count_o.
- R12: A gate rise or a load that falls in the same cycle as a tick is held until a later tick. In a mode with retrigger, a gate rise restarts timing at the next tick.
- R13: In mode codes 0, 1, 4 and 5, count_o equals (N - elapsed) mod 65536, so it wraps past zero and keeps counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Count enable; time advances one step per high cycle |
| load_i | input | 1 | One-cycle strobe that captures reload_i and mode_i |
| reload_i | input | 16 | Period to load; 0 stands for 65536 |
| mode_i | input | 3 | Operating mode code 0 to 7 |
| gate_i | input | 1 | Gate level; its rising edge retriggers modes 1, 2, 3 and 5 |
| count_o | output | 16 | Visible count |
| out_o | output | 1 | Output pin level |

## Verification
A tick can coincide with either a load strobe or a gate rise. Both coincidences matter because each event must be held over to a later tick rather than acting at once. The bench drives a load and a tick in the same cycle, a second load while a first is still pending, and a gate rise in a tick cycle, using sparse tick patterns. A behavioural model tracks elapsed ticks as an unbounded integer and is compared against out_o and count_o on every clock. If the design applied either event one tick early or late, the model would diverge in both outputs.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int IVC_CNT_W = 16;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } ivc_mode_e;

    typedef struct packed {
        logic done;
        logic pulse;
    } ivc_flags_t;

    // codes 6 and 7 fold onto the periodic modes
    function automatic ivc_mode_e ivc_norm(input logic [2:0] m);
        case (m)
            3'd6:    return M_RATE;
            3'd7:    return M_SQUARE;
            default: return ivc_mode_e'(m);
        endcase
    endfunction

    function automatic logic ivc_retrig(input ivc_mode_e m);
        return (m == M_ONESHOT) || (m == M_RATE) ||
               (m == M_SQUARE)  || (m == M_HWSTROBE);
    endfunction

endpackage

// File: rtl/ivc_load_stage.sv
module ivc_load_stage
    import ivc_pkg::*;
#(
    parameter int CNT_W = IVC_CNT_W,
    localparam int PER_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [2:0]       mode_i,
    output logic             pend_o,
    output logic [PER_W-1:0] pend_per_o,
    output ivc_mode_e        pend_mode_o
);
    localparam logic [PER_W-1:0] FULL = PER_W'(1) << CNT_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o      <= 1'b0;
            pend_per_o  <= FULL;
            pend_mode_o <= M_SQUARE;
        end else begin
            if (load_i) begin
                pend_o      <= 1'b1;
                pend_per_o  <= (reload_i == '0) ? FULL : {1'b0, reload_i};
                pend_mode_o <= ivc_norm(mode_i);
            end else if (tick_i) begin
                pend_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ivc_gate_trig.sv
module ivc_gate_trig (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic gate_i,
    output logic trig_o
);
    logic gate_q;
    logic rise;

    assign rise = gate_i & ~gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            trig_o <= 1'b0;
        end else begin
            gate_q <= gate_i;
            if (rise)
                trig_o <= 1'b1;
            else if (tick_i)
                trig_o <= 1'b0;
        end
    end
endmodule

// File: rtl/ivc_core.sv
module ivc_core
    import ivc_pkg::*;
#(
    parameter int CNT_W = IVC_CNT_W,
    localparam int PER_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             retrig_i,
    input  logic [PER_W-1:0] pend_per_i,
    input  ivc_mode_e        pend_mode_i,
    output logic [PER_W-1:0] per_o,
    output ivc_mode_e        mode_o,
    output logic [CNT_W-1:0] elap_o,
    output ivc_flags_t       flags_o
);
    localparam logic [PER_W-1:0] FULL = PER_W'(1) << CNT_W;

    logic [PER_W-1:0] per_nx;
    ivc_mode_e        mode_nx;
    logic [CNT_W-1:0] elap_nx;
    ivc_flags_t       flags_nx;
    logic             hit;

    // elapsed ticks about to reach the period
    assign hit = (({1'b0, elap_o} + PER_W'(1)) == per_o);

    always_comb begin
        per_nx   = per_o;
        mode_nx  = mode_o;
        elap_nx  = elap_o;
        flags_nx = flags_o;
        if (start_i) begin
            per_nx   = pend_per_i;
            mode_nx  = pend_mode_i;
            elap_nx  = '0;
            flags_nx = '0;
        end else if (tick_i) begin
            if (retrig_i) begin
                elap_nx  = '0;
                flags_nx = '0;
            end else begin
                case (mode_o)
                    M_RATE: begin
                        elap_nx        = hit ? '0 : elap_o + CNT_W'(1);
                        flags_nx.pulse = hit;
                    end
                    M_SQUARE: begin
                        elap_nx = hit ? '0 : elap_o + CNT_W'(1);
                    end
                    default: begin
                        elap_nx        = elap_o + CNT_W'(1);
                        flags_nx.pulse = hit & ~flags_o.done;
                        if (hit)
                            flags_nx.done = 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_o   <= FULL;
            mode_o  <= M_SQUARE;
            elap_o  <= '0;
            flags_o <= '0;
        end else begin
            per_o   <= per_nx;
            mode_o  <= mode_nx;
            elap_o  <= elap_nx;
            flags_o <= flags_nx;
        end
    end
endmodule

// File: rtl/ivc_wave.sv
module ivc_wave
    import ivc_pkg::*;
#(
    parameter int CNT_W = IVC_CNT_W,
    localparam int PER_W = CNT_W + 1
) (
    input  logic [PER_W-1:0] per_i,
    input  ivc_mode_e        mode_i,
    input  logic [CNT_W-1:0] elap_i,
    input  ivc_flags_t       flags_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);
    logic [PER_W:0]   per_inc;
    logic [PER_W-1:0] half;
    logic [PER_W-1:0] twice;
    logic [PER_W-1:0] rem;

    assign per_inc = {1'b0, per_i} + (PER_W+1)'(1);
    assign half    = per_inc[PER_W:1];
    assign twice   = {elap_i, 1'b0};
    assign rem     = (twice >= per_i) ? (twice - per_i) : twice;

    always_comb begin
        case (mode_i)
            M_TERM, M_ONESHOT: out_o = flags_i.done;
            M_SQUARE:          out_o = ({1'b0, elap_i} < half);
            default:           out_o = flags_i.pulse;
        endcase
        if (mode_i == M_SQUARE)
            count_o = CNT_W'(per_i - rem);
        else
            count_o = CNT_W'(per_i - {1'b0, elap_i});
    end
endmodule

// File: rtl/ivc_channel.sv
module ivc_channel
    import ivc_pkg::*;
#(
    parameter int CNT_W = IVC_CNT_W,
    localparam int PER_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [2:0]       mode_i,
    input  logic             gate_i,
    output logic [CNT_W-1:0] count_o,
    output logic             out_o
);
    logic             pend;
    logic [PER_W-1:0] pend_per;
    ivc_mode_e        pend_mode;
    logic             trig;
    logic [PER_W-1:0] per_q;
    ivc_mode_e        mode_q;
    logic [CNT_W-1:0] elap_q;
    ivc_flags_t       flags_q;
    logic             start_w;
    logic             retrig_w;
    logic             restart_w;

    assign start_w   = tick_i & pend;
    assign retrig_w  = tick_i & trig & ivc_retrig(mode_q);
    assign restart_w = start_w | retrig_w;

    ivc_load_stage #(.CNT_W(CNT_W)) u_load (
        .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
        .reload_i(reload_i), .mode_i(mode_i),
        .pend_o(pend), .pend_per_o(pend_per), .pend_mode_o(pend_mode)
    );

    ivc_gate_trig u_gate (
        .clk(clk), .rst(rst), .tick_i(tick_i), .gate_i(gate_i), .trig_o(trig)
    );

    ivc_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .tick_i(tick_i), .start_i(start_w),
        .retrig_i(retrig_w), .pend_per_i(pend_per), .pend_mode_i(pend_mode),
        .per_o(per_q), .mode_o(mode_q), .elap_o(elap_q), .flags_o(flags_q)
    );

    ivc_wave #(.CNT_W(CNT_W)) u_wave (
        .per_i(per_q), .mode_i(mode_q), .elap_i(elap_q), .flags_i(flags_q),
        .count_o(count_o), .out_o(out_o)
    );
endmodule

// File: rtl/ivc_channel_chk.sv
module ivc_channel_chk #(
    parameter int CNT_W = 16,
    localparam int PER_W = CNT_W + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic             out_o,
    input logic [CNT_W-1:0] count_o,
    input logic [2:0]       cur_mode,
    input logic             start_w,
    input logic             restart_w,
    input logic [PER_W-1:0] pend_per
);
    // R11
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(count_o) && $stable(out_o)));

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start_w |=> (count_o == $past(pend_per[CNT_W-1:0])));

    // R3
    term_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'd0 && out_o && !restart_w) |=> out_o);

    // R7
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        ((cur_mode == 3'd4 || cur_mode == 3'd5) && out_o && tick_i && !restart_w)
        |=> !out_o);

    // R5
    rate_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == 3'd2 && out_o && tick_i && !restart_w && count_o != CNT_W'(1))
        |=> !out_o);

    // R10
    mode_alias_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_mode != 3'd6) && (cur_mode != 3'd7));
endmodule

bind ivc_channel ivc_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .tick_i(tick_i), .out_o(out_o), .count_o(count_o),
    .cur_mode(mode_q), .start_w(start_w), .restart_w(restart_w),
    .pend_per(pend_per)
);

// File: tb/tb_ivc_channel.sv
module tb_ivc_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        load_i = 1'b0;
    logic [15:0] reload_i = '0;
    logic [2:0]  mode_i = '0;
    logic        gate_i = 1'b0;
    logic [15:0] count_o;
    logic        out_o;

    int    ncmp = 0;
    int    nfail = 0;
    bit    ended = 0;
    string tag = "R1";

    // behavioural reference state
    longint d;
    int     per, md, p_per, p_md;
    bit     pend, trig, gprev;

    ivc_channel dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .load_i(load_i),
        .reload_i(reload_i), .mode_i(mode_i), .gate_i(gate_i),
        .count_o(count_o), .out_o(out_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            d = 0; per = 65536; md = 3; p_per = 65536; p_md = 3;
            pend = 0; trig = 0; gprev = 0;
        end else begin
            if (tick_i) begin
                if (pend) begin
                    per = p_per; md = p_md; d = 0;
                end else if (trig && (md == 1 || md == 2 || md == 3 || md == 5))
                    d = 0;
                else
                    d = d + 1;
                pend = 0; trig = 0;
            end
            if (load_i) begin
                pend  = 1;
                p_per = (reload_i == 0) ? 65536 : int'(reload_i);
                p_md  = (mode_i == 6) ? 2 : (mode_i == 7) ? 3 : int'(mode_i);
            end
            if (gate_i && !gprev) trig = 1;
            gprev = gate_i;
        end
    end

    function automatic bit exp_out();
        case (md)
            0, 1:    return d >= per;
            2:       return (d % per == 0) && (d != 0);
            3:       return (d % per) < ((per + 1) / 2);
            default: return d == per;
        endcase
    endfunction

    function automatic logic [15:0] exp_cnt();
        longint v;
        case (md)
            2:       v = per - (d % per);
            3:       v = per - ((2 * d) % per);
            default: v = per - d;
        endcase
        return 16'(v & 64'hffff);
    endfunction

    always @(negedge clk) begin
        if (!rst && !ended) begin
            ncmp++;
            if (out_o !== exp_out() || count_o !== exp_cnt()) begin
                nfail++;
                $display("FAIL %s t=%0t out=%0b count=%0d expected out=%0b count=%0d",
                         tag, $time, out_o, count_o, exp_out(), exp_cnt());
            end
        end
    end

    task automatic step(input bit tk, input bit ld);
        @(posedge clk); #1;
        tick_i = tk; load_i = ld;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1, 0);
    endtask

    task automatic setup(input int m, input int v);
        mode_i = 3'(m); reload_i = 16'(v);
        step(0, 1);
        step(0, 0);
    endtask

    task automatic gate_pulse();
        @(posedge clk); #1; gate_i = 1'b1; tick_i = 1'b1; load_i = 1'b0;
        run(2);
        @(posedge clk); #1; gate_i = 1'b0;
    endtask

    task automatic finish_up();
        ended = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nfail);
        $finish;
    endtask

    initial begin
        #800000;
        if (!ended) begin
            nfail++;
            $display("FAIL watchdog expired");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        tag = "R1";  step(0, 0); step(0, 0); run(3);
        tag = "R3";  setup(0, 5); run(8);
        tag = "R9";  gate_pulse(); run(4);
        tag = "R4";  setup(1, 6); run(3); gate_pulse(); run(10);
        tag = "R5";  setup(2, 4); run(14); gate_pulse(); run(6);
        tag = "R5";  setup(2, 1); run(4);
        tag = "R6";  setup(3, 5); run(12); setup(3, 6); run(8); gate_pulse(); run(8);
        tag = "R7";  setup(4, 3); run(8);
        tag = "R9";  gate_pulse(); run(4);
        tag = "R8";  setup(5, 4); run(2); gate_pulse(); run(10);
        tag = "R10"; setup(6, 3); run(9); setup(7, 5); run(11);
        tag = "R11"; setup(2, 3);
        for (int i = 0; i < 30; i++) step((i % 3) == 0, 0);
        tag = "R12";
        mode_i = 3'd3; reload_i = 16'd7;
        step(1, 1); step(1, 0); run(5);
        mode_i = 3'd2; reload_i = 16'd5;
        step(0, 1); mode_i = 3'd4; reload_i = 16'd9; step(0, 1); step(0, 0); run(4);
        setup(2, 6); run(3);
        @(posedge clk); #1; gate_i = 1'b1; tick_i = 1'b1;
        step(0, 0); step(0, 0); step(1, 0); run(4);
        @(posedge clk); #1; gate_i = 1'b0; tick_i = 1'b0;
        tag = "R13"; setup(4, 2); run(6); setup(1, 3); run(5);
        tag = "R2";  setup(0, 0); run(65540);
        step(0, 0);
        finish_up();
    end
endmodule